// File: doc/BRIEF.md
# SMBus register-access slave

This block is a serial-bus slave that lets a host reach a bank of 8-bit registers. It watches the clock and data lines of a two-wire bus, recognises START and STOP, compares the 7-bit device address that follows each START with its own, and acknowledges a match by pulling the data line low through an open-drain enable. The bus lines are sampled on a fast system clock after a synchronizer, so the slave never drives the bus clock.

Access is indirect through a pointer. In a write transfer the first data byte always loads the pointer, and an optional second byte is written to the register the pointer selects. In a read transfer the byte at the current pointer is sent, so a read needs no pointer write if the pointer is already right. The register bank sits outside the block behind a plain read/write port: the pointer is the address, the read data is taken combinationally, and a one-cycle write strobe carries each write.

The upper five bits of the device address live in an internal address register that the host can rewrite. The lower two bits come from strap pins sampled while reset is held.

Top module: `smbus_reg_slave`

## Requirements
- R1: While reset is high the strap pins are sampled and the device address becomes {5'b01011, strap}; after reset `sda_oe` is 0, `reg_addr` is 0x00, and later strap changes do not alter the address.
- R2: A write of byte B while the pointer holds 0x40 sets the upper five address bits to B[6:2], keeps the strapped bits, raises no `reg_we`, and from the next START only the new address is acknowledged.
- R3: START is SDA falling while SCL is high and STOP is SDA rising while SCL is high; `sda_oe` changes only while SCL is low, and bytes clocked after a STOP without a new START get no acknowledge.
- R4: The address byte is the 7-bit address MSB first followed by R/W (1 = read); on a match the slave pulls SDA low in the ninth clock, otherwise it stays silent and ignores the bus until the next START.
- R5: The first data byte of a write transfer is loaded into the pointer, which drives `reg_addr`.
- R6: The second data byte of a write transfer produces exactly one `reg_we` pulse with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R7: Further data bytes of the same write transfer are acknowledged but cause no write and leave the pointer unchanged.
- R8: A read transfer sends, MSB first, the register the pointer selects without a preceding pointer write; with the pointer at 0x40 it sends {1'b0, device address}.
- R9: After a master ACK the same register is sent again (no pointer increment); after a master NACK the slave releases SDA and waits for a START.
- R10: A repeated START without a STOP restarts address matching, so a pointer write followed by a repeated-START read works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst | input | 1 | Synchronous active-high reset; strap pins sampled while high |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |
| strap_i | input | 2 | Hardwired low bits of the device address |
| reg_addr | output | 8 | Register bank address (the pointer) |
| reg_wdata | output | 8 | Register bank write data |
| reg_we | output | 1 | One-cycle register bank write strobe |
| reg_rdata | input | 8 | Register bank read data for `reg_addr` |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer, the address register at pointer 0x40 and the reset address prefix 01011, with the straps tied to 10 during reset and flipped afterwards. With a 16-cycle bus half-period the synchronizer latency stays well inside the low phase, which puts every acknowledge and read bit timing case within reach. Random pointers span every code except 0x40, so the bank path is covered broadly while directed transfers handle the address register, the renamed device and the stale address.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 7;
    localparam int HI_W    = 5;
    localparam int STRAP_W = ADDR_W - HI_W;
    localparam int BIT_CW  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK1,
        ST_RX_ACK2,
        ST_TX,
        ST_TX_ACK
    } xfer_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_PTR,
        PH_DATA,
        PH_EXTRA
    } byte_phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic [ADDR_W-1:0] compose_addr(
        input logic [HI_W-1:0]    hi,
        input logic [STRAP_W-1:0] lo
    );
        return {hi, lo};
    endfunction

    function automatic byte_phase_e next_phase(input byte_phase_e p);
        case (p)
            PH_ADDR: return PH_PTR;
            PH_PTR:  return PH_DATA;
            default: return PH_EXTRA;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import smb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_q;
    logic                   sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_q  <= scl_sh[TOP];
            sda_q  <= sda_sh[TOP];
        end
    end

    always_comb begin
        ev.scl      = scl_sh[TOP];
        ev.sda      = sda_sh[TOP];
        ev.scl_rise = scl_sh[TOP] & ~scl_q;
        ev.scl_fall = ~scl_sh[TOP] & scl_q;
        ev.start    = scl_sh[TOP] & scl_q & sda_q & ~sda_sh[TOP];
        ev.stop     = scl_sh[TOP] & scl_q & ~sda_q & sda_sh[TOP];
    end

endmodule

// File: rtl/smb_xfer_ctrl.sv
module smb_xfer_ctrl
    import smb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sda_oe,
    output logic              ptr_load,
    output logic              data_wr,
    output logic [BYTE_W-1:0] rx_byte
);

    xfer_state_e        state;
    byte_phase_e        phase;
    logic [BIT_CW-1:0]  cnt;
    logic [BYTE_W-1:0]  sh;
    logic               rw;
    logic               mack;

    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

    assign rx_byte = sh;

    always_ff @(posedge clk) begin
        ptr_load <= 1'b0;
        data_wr  <= 1'b0;
        if (rst) begin
            state  <= ST_IDLE;
            phase  <= PH_ADDR;
            cnt    <= '0;
            sh     <= '0;
            rw     <= 1'b0;
            mack   <= 1'b0;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            state  <= ST_RX;
            phase  <= PH_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (ev.scl_rise) begin
                        sh  <= {sh[BYTE_W-2:0], ev.sda};
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST_BIT) begin
                            if (phase == PH_ADDR && sh[ADDR_W-1:0] != dev_addr)
                                state <= ST_IDLE;
                            else
                                state <= ST_RX_ACK1;
                        end
                    end
                end
                ST_RX_ACK1: begin
                    if (ev.scl_fall) begin
                        sda_oe   <= 1'b1;
                        state    <= ST_RX_ACK2;
                        ptr_load <= (phase == PH_PTR);
                        data_wr  <= (phase == PH_DATA);
                        if (phase == PH_ADDR)
                            rw <= sh[0];
                    end
                end
                ST_RX_ACK2: begin
                    if (ev.scl_fall) begin
                        cnt   <= '0;
                        phase <= next_phase(phase);
                        if (phase == PH_ADDR && rw) begin
                            sh     <= tx_byte;
                            sda_oe <= ~tx_byte[BYTE_W-1];
                            state  <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        cnt <= cnt + 1'b1;
                        sh  <= {sh[BYTE_W-2:0], 1'b0};
                        if (cnt == LAST_BIT) begin
                            sda_oe <= 1'b0;
                            state  <= ST_TX_ACK;
                        end else begin
                            sda_oe <= ~sh[BYTE_W-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (ev.scl_rise)
                        mack <= ~ev.sda;
                    if (ev.scl_fall) begin
                        if (mack) begin
                            sh     <= tx_byte;
                            sda_oe <= ~tx_byte[BYTE_W-1];
                            cnt    <= '0;
                            state  <= ST_TX;
                        end else begin
                            state  <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !$past(ev.scl)); // R3

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe); // R4

    AST_MASTER_ACK_FREE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TX_ACK) |-> !sda_oe); // R9

endmodule

// File: rtl/smbus_reg_slave.sv
module smbus_reg_slave
    import smb_pkg::*;
#(
    parameter int                SYNC_STAGES  = 2,
    parameter logic [BYTE_W-1:0] ADDR_REG_PTR = 8'h40,
    parameter logic [HI_W-1:0]   ADDR_HI_RST  = 5'b01011
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [STRAP_W-1:0] strap_i,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [BYTE_W-1:0] reg_rdata
);

    line_ev_t           ev;
    logic               ptr_load;
    logic               data_wr;
    logic [BYTE_W-1:0]  rx_byte;
    logic [BYTE_W-1:0]  tx_byte;
    logic [BYTE_W-1:0]  pointer;
    logic [HI_W-1:0]    addr_hi;
    logic [STRAP_W-1:0] strap_q;
    logic [ADDR_W-1:0]  dev_addr;
    logic               hit_addr_reg;

    smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    smb_xfer_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .dev_addr (dev_addr),
        .tx_byte  (tx_byte),
        .sda_oe   (sda_oe),
        .ptr_load (ptr_load),
        .data_wr  (data_wr),
        .rx_byte  (rx_byte)
    );

    assign dev_addr     = compose_addr(addr_hi, strap_q);
    assign hit_addr_reg = (pointer == ADDR_REG_PTR);

    always_ff @(posedge clk) begin
        if (rst) begin
            strap_q <= strap_i;
            addr_hi <= ADDR_HI_RST;
            pointer <= '0;
        end else begin
            if (ptr_load)
                pointer <= rx_byte;
            if (data_wr && hit_addr_reg)
                addr_hi <= rx_byte[ADDR_W-1:STRAP_W];
        end
    end

    assign reg_addr  = pointer;
    assign reg_wdata = rx_byte;
    assign reg_we    = data_wr && !hit_addr_reg;
    assign tx_byte   = hit_addr_reg ? {1'b0, dev_addr} : reg_rdata;

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(strap_q)); // R1

    AST_BANK_SKIPS_ADDR_REG: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> (reg_addr != ADDR_REG_PTR)); // R2

    AST_WE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we); // R6

endmodule

// File: tb/smbus_reg_slave_test.sv
module smbus_reg_slave_test;

    localparam int Q = 8;
    localparam logic [6:0] DEF_ADDR = 7'h2E;
    localparam logic [6:0] NEW_ADDR = 7'h6E;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic       sda_oe;
    logic       reg_we;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       sda_line;

    logic [7:0] bank  [256];
    logic [7:0] model [256];

    int checks   = 0;
    int errors   = 0;
    int we_count = 0;
    int r3_viol  = 0;
    bit done     = 1'b0;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = bank[reg_addr];

    smbus_reg_slave uut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .strap_i   (strap),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) bank[i] <= 8'(i) ^ 8'hA5;
        end else if (reg_we) begin
            bank[reg_addr] <= reg_wdata;
            we_count++;
        end
    end

    logic scl_prev = 1'b1;
    logic oe_prev  = 1'b0;
    always @(negedge clk) begin
        if (!rst && scl_m && scl_prev && (sda_oe != oe_prev)) r3_viol++;
        scl_prev <= scl_m;
        oe_prev  <= sda_oe;
    end

    function automatic logic [7:0] addr_byte(input logic [6:0] a, input bit rd);
        return {a, rd};
    endfunction

    function automatic logic [7:0] addr_reg_image(input logic [6:0] a);
        return {1'b0, a};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = !sda_line;
        tick(Q);
        scl_m = 1'b0;
        tick(Q);
    endtask

    task automatic get_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line; tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = !give_ack; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0;
        sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d,
                            input bit with_data, output bit ka, output bit kp, output bit kd);
        bus_start;
        put_byte(addr_byte(a, 1'b0), ka);
        put_byte(p, kp);
        kd = 1'b0;
        if (with_data) put_byte(d, kd);
        bus_stop;
        if (ka && with_data && p != 8'h40) model[p] = d;
    endtask

    task automatic do_read(input logic [6:0] a, input int n, input logic [7:0] exp, input string req);
        bit ka;
        logic [7:0] b;
        bus_start;
        put_byte(addr_byte(a, 1'b1), ka);
        chk(ka, {req, " read address ack"}, ka, 1);
        if (ka) begin
            for (int i = 0; i < n; i++) begin
                get_byte(i != n - 1, b);
                chk(b == exp, req, b, exp);
            end
        end
        bus_stop;
    endtask

    initial begin
        bit ka, kp, kd, k3;
        logic [7:0] b;
        int wc;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) model[i] = 8'(i) ^ 8'hA5;

        tick(10);
        rst = 1'b0;
        tick(2);
        // R1: reset state
        chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
        chk(reg_addr == 8'h00, "R1 pointer after reset", reg_addr, 0);
        strap = 2'b01;
        tick(4);

        // R1 R4 R5 R6: default address with straps taken at reset
        do_write(DEF_ADDR, 8'h12, 8'h5A, 1'b1, ka, kp, kd);
        chk(ka, "R1 R4 default address acknowledged", ka, 1);
        chk(kp && kd, "R4 data bytes acknowledged", {kp, kd}, 3);
        chk(reg_addr == 8'h12, "R5 pointer loaded", reg_addr, 8'h12);
        chk(bank[8'h12] == 8'h5A, "R6 register written", bank[8'h12], 8'h5A);
        chk(we_count == 1, "R6 single write strobe", we_count, 1);

        // R5: pointer-only write
        do_write(DEF_ADDR, 8'h30, 8'h00, 1'b0, ka, kp, kd);
        chk(reg_addr == 8'h30, "R5 pointer-only write", reg_addr, 8'h30);
        chk(we_count == 1, "R5 no strobe on pointer-only", we_count, 1);

        // R7: extra bytes ignored
        bus_start;
        put_byte(addr_byte(DEF_ADDR, 1'b0), ka);
        put_byte(8'h21, kp);
        put_byte(8'h77, kd);
        put_byte(8'h99, k3);
        bus_stop;
        model[8'h21] = 8'h77;
        chk(k3, "R7 extra byte acknowledged", k3, 1);
        chk(bank[8'h21] == 8'h77, "R7 extra byte not written", bank[8'h21], 8'h77);
        chk(we_count == 2, "R7 strobe count", we_count, 2);
        chk(reg_addr == 8'h21, "R7 pointer unchanged", reg_addr, 8'h21);

        // R4: mismatching address is ignored
        bus_start;
        put_byte(addr_byte(7'h2F, 1'b0), ka);
        chk(!ka, "R4 no ack for other address", ka, 0);
        put_byte(8'h05, kp);
        chk(!kp, "R4 silent after mismatch", kp, 0);
        bus_stop;
        chk(reg_addr == 8'h21, "R4 pointer untouched", reg_addr, 8'h21);

        // R8 R9: read without pointer write, repeated with master ack
        bus_start;
        put_byte(addr_byte(DEF_ADDR, 1'b1), ka);
        chk(ka, "R8 read address ack", ka, 1);
        for (int i = 0; i < 3; i++) begin
            get_byte(i != 2, b);
            chk(b == model[8'h21], "R8 R9 read byte", b, model[8'h21]);
        end
        tick(Q);
        chk(sda_oe == 1'b0, "R9 released after nack", sda_oe, 0);
        bus_stop;

        // R3: bytes after STOP without START get no ack
        scl_m = 1'b0; tick(Q);
        put_byte(addr_byte(DEF_ADDR, 1'b0), ka);
        chk(!ka, "R3 no ack without START", ka, 0);
        bus_stop;

        // R10: repeated START
        bus_start;
        put_byte(addr_byte(7'h11, 1'b0), ka);
        chk(!ka, "R10 first address mismatch", ka, 0);
        bus_start;
        put_byte(addr_byte(DEF_ADDR, 1'b0), ka);
        chk(ka, "R10 repeated START matches", ka, 1);
        put_byte(8'h44, kp);
        bus_start;
        put_byte(addr_byte(DEF_ADDR, 1'b1), ka);
        chk(ka, "R10 repeated START read ack", ka, 1);
        get_byte(1'b0, b);
        chk(b == model[8'h44], "R10 combined read", b, model[8'h44]);
        bus_stop;

        // R2: rewrite the device address
        wc = we_count;
        do_write(DEF_ADDR, 8'h40, 8'h6C, 1'b1, ka, kp, kd);
        chk(ka && kp && kd, "R2 address register write acked", {ka, kp, kd}, 7);
        chk(we_count == wc, "R2 bank not strobed", we_count, wc);
        chk(bank[8'h40] == model[8'h40], "R2 bank slot untouched", bank[8'h40], model[8'h40]);
        do_write(DEF_ADDR, 8'h10, 8'h00, 1'b0, ka, kp, kd);
        chk(!ka, "R2 old address rejected", ka, 0);
        do_read(NEW_ADDR, 1, addr_reg_image(NEW_ADDR), "R2 R8 address register readback");

        // R6 R8: random traffic
        for (int n = 0; n < 16; n++) begin
            logic [7:0] p;
            logic [7:0] d;
            bit wd;
            p  = 8'($urandom_range(0, 255));
            if (p == 8'h40) p = 8'h41;
            d  = 8'($urandom);
            wd = ($urandom_range(0, 3) != 0);
            do_write(NEW_ADDR, p, d, wd, ka, kp, kd);
            chk(ka && kp, "R5 random pointer write acked", {ka, kp}, 3);
            do_read(NEW_ADDR, 1, model[p], "R6 R8 random readback");
        end

        chk(r3_viol == 0, "R3 sda_oe moved while SCL high", r3_viol, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule